// File: doc/BRIEF.md
# Shadow memory region attribute controller

This block sits beside a CPU memory path and decides, for every access that falls in the upper half of a 1 MB address space, where the access should go. An access is either served by on-board RAM, passed to the external bus, or, when it is a write aimed at a region that has been made read-only, dropped. The decision is combinational, so the route for an address is known in the same cycle the address is presented.

The routing is set up through five 16-bit registers on a small I/O port bus, each of which reads back what was last written. Two granularities are offered. In coarse mode the space from 0x80000 upward is split into four 128 KB regions (base-memory extension, video, option ROM, system ROM) whose enables live in the memory configuration register at 0x22. In fine mode, selected by bit 0 of the register at 0x2C, the 256 KB from 0xC0000 is instead split into eight 32 KB segments controlled by the segment map register at 0x2E. A lock bit in register 0x22 freezes the whole register set until reset and at the same time makes enabled coarse ROM shadows read-only, which is how firmware copies ROM into RAM and then protects it.

A status output reports whether the segment holding the start of the system ROM is currently shadowed; the ROM start depends on a size bit in register 0x22.

Top module: `shadow_route_ctrl`

## Requirements
- R1: A register at I/O address 0x22, 0x28, 0x2A, 0x2C or 0x2E returns its last written 16-bit value on io_rdata one clock after io_addr is presented; any other address reads as zero and a write to it changes no register.
- R2: After reset every register reads zero except 0x28, which reads 0x00F9; the lock is clear and rom_shadowed is 0.
- R3: Bit 15 of register 0x22 is the lock. The write that sets it takes full effect; while it is set every register write is ignored; only reset clears it.
- R4: When mem_valid is high exactly one of route_int, route_ext, route_blk is high, decided combinationally from the address in the same cycle; when mem_valid is low all three are low.
- R5: Addresses below 0x80000 always route to internal RAM, reads and writes.
- R6: The range 0x80000-0x9FFFF routes to internal RAM when bit 3 of 0x22 is set and to the external bus when it is clear, in either granularity.
- R7: The range 0xA0000-0xBFFFF is shadowed when bit 10 of 0x22 is set; bit 11 set makes it read/write, clear makes it read-only; this holds in either granularity.
- R8: In coarse mode (bit 0 of 0x2C clear) bit 9 of 0x22 enables 0xC0000-0xDFFFF and bit 0 enables 0xE0000-0xFFFFF; an enabled one is read-only while the lock is set and read/write otherwise. A disabled region sends reads and writes to the external bus.
- R9: In fine mode (bit 0 of 0x2C set) segment i (0..7) covers 0xC0000 + i*0x8000 for 32 KB; bit i+8 of 0x2E enables it, and bit i set makes it read-only; bits 9 and 0 of 0x22 and the lock do not affect these segments.
- R10: A read of an enabled read-only region routes to internal RAM; a write to it raises route_blk and neither of the other routes.
- R11: The system ROM starts at 0xE0000 when bit 8 of 0x22 is set and at 0xF0000 when clear; rom_shadowed is high when the segment (fine) or region (coarse) containing that start is enabled.
- R12: A register write changes routing for an access presented in the cycle right after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address for register read or write |
| io_we | input | 1 | Register write strobe |
| io_wdata | input | 16 | Register write data |
| io_rdata | output | 16 | Registered read-back of the addressed register |
| mem_valid | input | 1 | Memory access present |
| mem_addr | input | 20 | Memory access byte address |
| mem_write | input | 1 | Access is a write |
| route_int | output | 1 | Access goes to on-board RAM |
| route_ext | output | 1 | Access goes to the external bus |
| route_blk | output | 1 | Write dropped, read-only target |
| rom_shadowed | output | 1 | System ROM start segment is shadowed |

## Verification
The route decision is swept over every 32 KB step of the address space, as both read and write, for all 64 combinations of the six coarse control bits of register 0x22, which separates each region's enable from its neighbours' and the video write-enable from the ROM ones. Fine mode is swept the same way under sixteen segment-map patterns with the coarse ROM enables deliberately set, which tells fine-segment decoding from any leakage of the coarse bits and catches an off-by-one segment index. Locking is tried with ROM shadows enabled so that read-only conversion, write blocking and the freezing of later writes are each seen at the routes and at read-back, and reset afterwards shows the lock clears.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [2:0] {
    RT_NONE = 3'b000,
    RT_INT  = 3'b001,
    RT_EXT  = 3'b010,
    RT_BLK  = 3'b100
  } route_t;

  localparam int NREG = 5;

  // register slots
  localparam int SLOT_MEMCFG = 0;
  localparam int SLOT_AUXA   = 1;
  localparam int SLOT_AUXB   = 2;
  localparam int SLOT_GRAN   = 3;
  localparam int SLOT_SEGMAP = 4;

  // bit positions within the memory configuration register
  localparam int B_SYS_EN  = 0;
  localparam int B_BASE_EN = 3;
  localparam int B_ROM_BIG = 8;
  localparam int B_OPT_EN  = 9;
  localparam int B_VID_EN  = 10;
  localparam int B_VID_RW  = 11;
  localparam int B_LOCK    = 15;
  localparam int B_FINE    = 0;

  function automatic logic [7:0] slot_addr(input int s);
    case (s)
      SLOT_MEMCFG: return 8'h22;
      SLOT_AUXA:   return 8'h28;
      SLOT_AUXB:   return 8'h2A;
      SLOT_GRAN:   return 8'h2C;
      default:     return 8'h2E;
    endcase
  endfunction

  function automatic logic [15:0] slot_reset(input int s);
    return (s == SLOT_AUXA) ? 16'h00F9 : 16'h0000;
  endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import shadow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_we,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] memcfg,
  output logic [DATA_W-1:0] segmap,
  output logic              fine_mode,
  output logic              locked
);

  logic [DATA_W-1:0] regs_q [NREG];
  logic [NREG-1:0]   hit;

  assign locked = regs_q[SLOT_MEMCFG][B_LOCK];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      assign hit[g] = (io_addr == IO_AW'(slot_addr(g)));
      always_ff @(posedge clk) begin
        if (rst)
          regs_q[g] <= DATA_W'(slot_reset(g));
        else if (io_we && hit[g] && !locked)
          regs_q[g] <= io_wdata;
      end
    end
  endgenerate

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NREG; k++)
      if (hit[k]) rd_mux = regs_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else     io_rdata <= rd_mux;
  end

  assign memcfg    = regs_q[SLOT_MEMCFG];
  assign segmap    = regs_q[SLOT_SEGMAP];
  assign fine_mode = regs_q[SLOT_GRAN][B_FINE];

endmodule

// File: rtl/region_decode.sv
module region_decode
  import shadow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 20,
  parameter int SEG_N  = 8
) (
  input  logic              mem_valid,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_write,
  input  logic [DATA_W-1:0] memcfg,
  input  logic [DATA_W-1:0] segmap,
  input  logic              fine_mode,
  input  logic              locked,
  output route_t            route
);

  localparam int SEG_W = $clog2(SEG_N);

  logic [2:0]       region;
  logic [SEG_W-1:0] seg;
  logic             fine_win;
  logic             en, ro;

  assign region   = mem_addr[MEM_AW-1 -: 3];
  assign fine_win = (mem_addr[MEM_AW-1 -: 2] == 2'b11);
  assign seg      = mem_addr[MEM_AW-3 -: SEG_W];

  always_comb begin
    en = 1'b1;
    ro = 1'b0;
    case (region)
      3'd4: en = memcfg[B_BASE_EN];
      3'd5: begin en = memcfg[B_VID_EN]; ro = !memcfg[B_VID_RW]; end
      3'd6: begin en = memcfg[B_OPT_EN]; ro = locked; end
      3'd7: begin en = memcfg[B_SYS_EN]; ro = locked; end
      default: begin en = 1'b1; ro = 1'b0; end
    endcase
    if (fine_mode && fine_win) begin
      en = segmap[SEG_N + 32'(seg)];
      ro = segmap[seg];
    end
  end

  always_comb begin
    if (!mem_valid)          route = RT_NONE;
    else if (!en)            route = RT_EXT;
    else if (ro && mem_write) route = RT_BLK;
    else                     route = RT_INT;
  end

endmodule

// File: rtl/rom_status.sv
module rom_status
  import shadow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memcfg,
  input  logic [DATA_W-1:0] segmap,
  input  logic              fine_mode,
  output logic              rom_shadowed
);

  localparam int SEG_BIG   = SEG_N / 2;
  localparam int SEG_SMALL = (SEG_N * 3) / 4;

  logic shadowed_c;
  always_comb begin
    if (fine_mode)
      shadowed_c = memcfg[B_ROM_BIG] ? segmap[SEG_N + SEG_BIG] : segmap[SEG_N + SEG_SMALL];
    else
      shadowed_c = memcfg[B_SYS_EN];
  end

  // combinational view of registered configuration; clk/rst kept for a registered variant
  logic unused_ok;
  assign unused_ok = clk ^ rst;
  assign rom_shadowed = shadowed_c;

endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shadow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_AW  = 8,
  parameter int MEM_AW = 20,
  parameter int SEG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_we,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              mem_valid,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_write,
  output logic              route_int,
  output logic              route_ext,
  output logic              route_blk,
  output logic              rom_shadowed
);

  logic [DATA_W-1:0] memcfg, segmap;
  logic              fine_mode, cfg_lock;
  route_t            route;

  cfg_regs #(.DATA_W(DATA_W), .IO_AW(IO_AW)) u_regs (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .memcfg(memcfg),
    .segmap(segmap), .fine_mode(fine_mode), .locked(cfg_lock)
  );

  region_decode #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .SEG_N(SEG_N)) u_dec (
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
    .memcfg(memcfg), .segmap(segmap), .fine_mode(fine_mode),
    .locked(cfg_lock), .route(route)
  );

  rom_status #(.DATA_W(DATA_W), .SEG_N(SEG_N)) u_rom (
    .clk(clk), .rst(rst), .memcfg(memcfg), .segmap(segmap),
    .fine_mode(fine_mode), .rom_shadowed(rom_shadowed)
  );

  assign route_int = route[0];
  assign route_ext = route[1];
  assign route_blk = route[2];

endmodule

// File: rtl/shadow_route_ctrl_chk.sv
module shadow_route_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              io_we,
  input logic              mem_valid,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_write,
  input logic              route_int,
  input logic              route_ext,
  input logic              route_blk,
  input logic              lock,
  input logic [DATA_W-1:0] memcfg,
  input logic [DATA_W-1:0] segmap,
  input logic              fine_mode
);

  a_r4_route_onehot: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> $countones({route_int, route_ext, route_blk}) == 1);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !mem_valid |-> !(route_int || route_ext || route_blk));

  a_r5_low_internal: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_addr[MEM_AW-1]) |-> route_int);

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);

  a_r3_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    (lock && io_we) |=> ($stable(memcfg) && $stable(segmap) && $stable(fine_mode)));

  a_r10_blk_only_write: assert property (@(posedge clk) disable iff (rst)
    route_blk |-> mem_write);

endmodule

bind shadow_route_ctrl shadow_route_ctrl_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst(rst), .io_we(io_we), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .mem_write(mem_write), .route_int(route_int),
  .route_ext(route_ext), .route_blk(route_blk), .lock(cfg_lock),
  .memcfg(memcfg), .segmap(segmap), .fine_mode(fine_mode)
);

// File: tb/shadow_route_ctrl_test.sv
`timescale 1ns/1ps
module shadow_route_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_addr = '0;
  logic        io_we = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        mem_valid = 1'b0;
  logic [19:0] mem_addr = '0;
  logic        mem_write = 1'b0;
  logic        route_int, route_ext, route_blk, rom_shadowed;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_route_ctrl uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_write(mem_write), .route_int(route_int),
    .route_ext(route_ext), .route_blk(route_blk), .rom_shadowed(rom_shadowed)
  );

  // bench-side shadow of the register contents
  logic [15:0] m22, m2c, m2e;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    io_addr = a;
    @(negedge clk);
    d = io_rdata;
  endtask

  // expected route {blk, ext, int}
  function automatic logic [2:0] model(input logic [15:0] c, input logic [15:0] s,
                                       input logic fine, input int a, input logic w);
    int r; logic en, ro; int k;
    r = a / 32'h20000;
    en = 1'b1; ro = 1'b0;
    if (r == 4) en = c[3];
    else if (r == 5) begin en = c[10]; ro = !c[11]; end
    else if (r == 6) begin en = c[9]; ro = c[15]; end
    else if (r == 7) begin en = c[0]; ro = c[15]; end
    if (fine && a >= 32'hC0000) begin
      k = (a - 32'hC0000) / 32'h8000;
      en = s[8 + k]; ro = s[k];
    end
    if (!en) return 3'b010;
    if (ro && w) return 3'b100;
    return 3'b001;
  endfunction

  function automatic logic rom_model(input logic [15:0] c, input logic [15:0] s, input logic fine);
    if (!fine) return c[0];
    return c[8] ? s[8 + 4] : s[8 + 6];
  endfunction

  task automatic access(input int a, input logic w, input string tag);
    mem_valid = 1'b1; mem_addr = 20'(a); mem_write = w;
    #1;
    chk(tag, {route_blk, route_ext, route_int}, model(m22, m2e, m2c[0], a, w));
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 32; a++)
      for (int w = 0; w < 2; w++)
        access(a * 32'h8000 + (a % 7) * 32'h111, w[0], tag);
    mem_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    m22 = 0; m2c = 0; m2e = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset values
    rd(8'h22, d); chk("R2 reg22", d, 16'h0000);
    rd(8'h28, d); chk("R2 reg28", d, 16'h00F9);
    rd(8'h2A, d); chk("R2 reg2A", d, 16'h0000);
    rd(8'h2C, d); chk("R2 reg2C", d, 16'h0000);
    rd(8'h2E, d); chk("R2 reg2E", d, 16'h0000);
    chk("R2 rom_shadowed", rom_shadowed, 1'b0);

    // R4 idle
    mem_valid = 1'b0; mem_addr = 20'hC1234; #1;
    chk("R4 idle", {route_blk, route_ext, route_int}, 3'b000);

    // R1 read-back and unknown address
    wr(8'h2A, 16'hA55A); rd(8'h2A, d); chk("R1 reg2A", d, 16'hA55A);
    wr(8'h28, 16'h1234); rd(8'h28, d); chk("R1 reg28", d, 16'h1234);
    wr(8'h24, 16'hFFFF); rd(8'h24, d); chk("R1 unknown read", d, 16'h0000);
    rd(8'h22, d); chk("R1 unknown write ignored", d, 16'h0000);
    mem_valid = 1'b1; mem_addr = 20'h80000; mem_write = 1'b0; #1;
    chk("R1 unknown write no route change", {route_blk, route_ext, route_int}, 3'b010);
    mem_valid = 1'b0;

    // coarse sweep R5 R6 R7 R8 R10 R11 R12
    for (int c = 0; c < 64; c++) begin
      m22 = {4'b0, c[5], c[4], c[3], c[2], 4'b0, c[1], 2'b0, c[0]};
      wr(8'h22, m22);
      access(32'hE4000, 1'b1, "R12 next access");
      sweep("R5/R6/R7/R8/R10 coarse");
      chk("R11 coarse rom", rom_shadowed, rom_model(m22, m2e, 1'b0));
    end
    rd(8'h22, d); chk("R1 reg22", d, m22);

    // fine sweep R9 R11
    m2c = 16'h0001; wr(8'h2C, m2c);
    for (int p = 0; p < 16; p++) begin
      m2e = 16'(p * 32'h3B1D) ^ 16'(p << 12);
      m22 = 16'h0201 | (p[0] ? 16'h0100 : 16'h0) | (p[1] ? 16'h0C08 : 16'h0400);
      wr(8'h2E, m2e);
      wr(8'h22, m22);
      sweep("R9 fine");
      chk("R11 fine rom", rom_shadowed, rom_model(m22, m2e, 1'b1));
    end

    // lock R3 R8 R10
    m2c = 16'h0000; wr(8'h2C, m2c);
    m2e = 16'h0000; wr(8'h2E, m2e);
    m22 = 16'h8201; wr(8'h22, m22);
    rd(8'h22, d); chk("R3 lock write takes effect", d, 16'h8201);
    mem_valid = 1'b1; mem_addr = 20'hC8000; mem_write = 1'b1; #1;
    chk("R8 locked option rom write", {route_blk, route_ext, route_int}, 3'b100);
    mem_write = 1'b0; #1;
    chk("R10 locked option rom read", {route_blk, route_ext, route_int}, 3'b001);
    mem_valid = 1'b0;
    sweep("R8 locked coarse");
    wr(8'h22, 16'h0000);
    wr(8'h2C, 16'h0001);
    wr(8'h28, 16'h0000);
    rd(8'h22, d); chk("R3 reg22 frozen", d, 16'h8201);
    rd(8'h2C, d); chk("R3 reg2C frozen", d, 16'h0000);
    rd(8'h28, d); chk("R3 reg28 frozen", d, 16'h1234);
    sweep("R3 routes frozen");

    // reset clears lock
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    m22 = 0; m2c = 0; m2e = 0;
    wr(8'h2E, 16'h5A5A); rd(8'h2E, d); chk("R3 unlocked after reset", d, 16'h5A5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule